// File: doc/BRIEF.md
# ADC Conversion Status Flag Register

This block holds the event flags of a twelve-channel analog front-end controller and presents them as one 32-bit read-only status word. Conversion-complete strobes, an overrun strobe, a comparator-error strobe and a temperature-window hit come in from the converter logic. Each of them sets a flag that stays set until a particular register read clears it.

Each flag has its own clearing read. Reading the status word clears the three sticky error and event flags. Reading the last-converted-data register clears the data-ready flag. Reading the channel-data register clears only the end-of-conversion flag of the channel that the channel selector names. The read bus uses a one-cycle strobe, a two-bit address and the selector. The data for the two data registers is supplied elsewhere, so this block returns the status word only for the status address.

A level interrupt is raised while any flag is set and its matching mask bit is enabled.

Top module: `adc_status_flags`

## Requirements
- R1: After reset every flag is zero. The status word uses these bits: 0..NUM_CH-1 are end-of-conversion for channel 0..NUM_CH-1, 24 is data ready, 25 is overrun, 26 is comparison error, 30 is temperature change. All other bits always read zero.
- R2: A conversion-complete strobe for an enabled channel x sets end-of-conversion flag x on the next clock edge.
- R3: The end-of-conversion flag of a disabled channel reads zero. A completion strobe on a disabled channel is ignored. A flag dropped by disabling its channel stays zero after the channel is re-enabled, until a new completion arrives.
- R4: End-of-conversion flag x is cleared only by a channel-data read (address 2) while the selector equals x. A channel-data read with another selector, including one at or above NUM_CH, leaves the flag unchanged.
- R5: Data ready is set by a completion on any enabled channel. It is cleared only by a last-data read (address 1). A status read does not clear it.
- R6: The overrun and comparison-error flags are set by their strobes. A status read (address 0) clears them.
- R7: The temperature-change flag is set when the window-hit input is high in the same cycle that the temperature channel (channel NUM_CH-1) completes while enabled. A window hit without that completion is ignored. A status read clears the flag.
- R8: When a set event and its clearing read fall in the same cycle, the flag is set after the edge.
- R9: During a status read strobe, rdData holds the flags as they were before that read clears them. For any other address, or with no strobe, rdData is zero.
- R10: irq is high exactly while some status bit and the same bit of irqMask are both one.
- R11: Address 3, and any address while rdStb is low, clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEnable | input | NUM_CH | Per-channel enable |
| convDone | input | NUM_CH | Per-channel conversion-complete strobe |
| tempWinHit | input | 1 | Temperature result satisfies the compare window |
| ovrEvt | input | 1 | General overrun strobe |
| cmpErrEvt | input | 1 | Comparison error strobe |
| rdStb | input | 1 | One-cycle read strobe |
| rdAddr | input | 2 | 0 status, 1 last data, 2 channel data, 3 unused |
| chanSel | input | SEL_W | Channel selector for channel-data reads |
| irqMask | input | 32 | Interrupt enable per status bit |
| rdData | output | 32 | Status word during a status read, else zero |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default NUM_CH of 12. With a four-bit selector, that leaves selector codes 12 to 15, so the bench can show that an out-of-range channel-data read clears nothing. It also makes channel 11 the temperature channel, so the window-hit qualification and end-of-conversion flag 11 can be exercised in the same cycle.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W    = 32;
  localparam int BIT_DRDY  = 24;
  localparam int BIT_OVR   = 25;
  localparam int BIT_CMPE  = 26;
  localparam int BIT_TEMP  = 30;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_LAST   = 2'd1,
    ADDR_CHAN   = 2'd2,
    ADDR_NONE   = 2'd3
  } rdAddr_e;

  typedef struct packed {
    logic rdStatus;
    logic clrLast;
    logic clrChan;
  } clrStrobes_t;
endpackage

// File: rtl/adc_stat_flag.sv
module adc_stat_flag (
  input  logic clk,
  input  logic rstN,
  input  logic forceLow,
  input  logic setEv,
  input  logic clrEv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN)         q <= 1'b0;
    else if (forceLow) q <= 1'b0;
    else if (setEv)    q <= 1'b1;
    else if (clrEv)    q <= 1'b0;
  end
endmodule

// File: rtl/adc_stat_ctrl.sv
module adc_stat_ctrl
  import adc_stat_pkg::*;
(
  input  logic        rdStb,
  input  logic [1:0]  rdAddr,
  output clrStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (rdStb) begin
      unique case (rdAddr_e'(rdAddr))
        ADDR_STATUS: strobes.rdStatus = 1'b1;
        ADDR_LAST:   strobes.clrLast  = 1'b1;
        ADDR_CHAN:   strobes.clrChan  = 1'b1;
        default:     strobes          = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_stat_datapath.sv
module adc_stat_datapath
  import adc_stat_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   chEnable,
  input  logic [NUM_CH-1:0]   convDone,
  input  logic                tempWinHit,
  input  logic                ovrEvt,
  input  logic                cmpErrEvt,
  input  logic [SEL_W-1:0]    chanSel,
  input  logic [STAT_W-1:0]   irqMask,
  input  clrStrobes_t         strobes,
  output logic [STAT_W-1:0]   statusWord,
  output logic [STAT_W-1:0]   rdData,
  output logic                irq
);
  localparam int TEMP_CH = NUM_CH - 1;

  logic [NUM_CH-1:0] eocQ;
  logic [NUM_CH-1:0] liveDone;
  logic drdyQ, ovrQ, cmpQ, tempQ;

  assign liveDone = convDone & chEnable;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_eoc
    logic selHit;
    assign selHit = strobes.clrChan && (chanSel == SEL_W'(i));
    adc_stat_flag u_eoc (
      .clk(clk), .rstN(rstN),
      .forceLow(!chEnable[i]),
      .setEv(liveDone[i]),
      .clrEv(selHit),
      .q(eocQ[i])
    );
  end

  adc_stat_flag u_drdy (
    .clk(clk), .rstN(rstN), .forceLow(1'b0),
    .setEv(|liveDone), .clrEv(strobes.clrLast), .q(drdyQ)
  );
  adc_stat_flag u_ovr (
    .clk(clk), .rstN(rstN), .forceLow(1'b0),
    .setEv(ovrEvt), .clrEv(strobes.rdStatus), .q(ovrQ)
  );
  adc_stat_flag u_cmp (
    .clk(clk), .rstN(rstN), .forceLow(1'b0),
    .setEv(cmpErrEvt), .clrEv(strobes.rdStatus), .q(cmpQ)
  );
  adc_stat_flag u_temp (
    .clk(clk), .rstN(rstN), .forceLow(1'b0),
    .setEv(tempWinHit && liveDone[TEMP_CH]), .clrEv(strobes.rdStatus), .q(tempQ)
  );

  always_comb begin
    statusWord              = '0;
    statusWord[NUM_CH-1:0]  = eocQ & chEnable;
    statusWord[BIT_DRDY]    = drdyQ;
    statusWord[BIT_OVR]     = ovrQ;
    statusWord[BIT_CMPE]    = cmpQ;
    statusWord[BIT_TEMP]    = tempQ;
  end

  assign rdData = strobes.rdStatus ? statusWord : '0;
  assign irq    = |(statusWord & irqMask);
endmodule

// File: rtl/adc_status_flags.sv
module adc_status_flags
  import adc_stat_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int SEL_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] convDone,
  input  logic              tempWinHit,
  input  logic              ovrEvt,
  input  logic              cmpErrEvt,
  input  logic              rdStb,
  input  logic [1:0]        rdAddr,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic [31:0]       irqMask,
  output logic [31:0]       rdData,
  output logic              irq
);
  clrStrobes_t       strobes;
  logic [STAT_W-1:0] statusWord;

  adc_stat_ctrl u_ctrl (
    .rdStb(rdStb), .rdAddr(rdAddr), .strobes(strobes)
  );

  adc_stat_datapath #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .convDone(convDone),
    .tempWinHit(tempWinHit), .ovrEvt(ovrEvt), .cmpErrEvt(cmpErrEvt),
    .chanSel(chanSel), .irqMask(irqMask), .strobes(strobes),
    .statusWord(statusWord), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/adc_status_flags_chk.sv
module adc_status_flags_chk #(
  parameter int NUM_CH = 12,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] convDone,
  input logic              tempWinHit,
  input logic              ovrEvt,
  input logic              cmpErrEvt,
  input logic              rdStb,
  input logic [1:0]        rdAddr,
  input logic [SEL_W-1:0]  chanSel,
  input logic [31:0]       irqMask,
  input logic [31:0]       rdData,
  input logic              irq,
  input logic [31:0]       statusWord
);
  logic [31:0] usedBits;
  logic [NUM_CH-1:0] selOh;
  assign usedBits = {1'b0, 1'b1, 3'b0, 3'b111, {(24-NUM_CH){1'b0}}, {NUM_CH{1'b1}}};
  assign selOh    = NUM_CH'(1) << chanSel;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~usedBits) == 32'd0);

  p_eoc_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    |(convDone & chEnable) |=>
      ((($past(convDone & chEnable) & chEnable) & ~statusWord[NUM_CH-1:0]) == '0));

  p_disabled_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[NUM_CH-1:0] & ~chEnable) == '0);

  p_other_sel_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdAddr == 2'd2) |=>
      (($past(statusWord[NUM_CH-1:0] & ~selOh) & chEnable & ~statusWord[NUM_CH-1:0]) == '0));

  p_drdy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[24] && !(rdStb && rdAddr == 2'd1)) |=> statusWord[24]);

  p_status_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdAddr == 2'd0 && !ovrEvt && !cmpErrEvt) |=> !statusWord[25] && !statusWord[26]);

  p_temp_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[30] && !(tempWinHit && convDone[NUM_CH-1] && chEnable[NUM_CH-1])) |=> !statusWord[30]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovrEvt || cmpErrEvt) |=> ((statusWord[25] || !$past(ovrEvt)) && (statusWord[26] || !$past(cmpErrEvt))));

  p_rddata_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdData == ((rdStb && rdAddr == 2'd0) ? statusWord : 32'd0));

  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((statusWord & irqMask) != 32'd0));

  p_idle_no_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb || rdAddr == 2'd3) |=> (($past(statusWord) & ~statusWord & {8'hFF, {24{1'b0}}}) == 32'd0));
endmodule

bind adc_status_flags adc_status_flags_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .chEnable(chEnable), .convDone(convDone),
  .tempWinHit(tempWinHit), .ovrEvt(ovrEvt), .cmpErrEvt(cmpErrEvt),
  .rdStb(rdStb), .rdAddr(rdAddr), .chanSel(chanSel), .irqMask(irqMask),
  .rdData(rdData), .irq(irq), .statusWord(statusWord)
);

// File: tb/tb_adc_status_flags.sv
`timescale 1ns/1ps
module tb_adc_status_flags;
  localparam int NUM_CH = 12;
  localparam int SEL_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] chEnable = '1;
  logic [NUM_CH-1:0] convDone = '0;
  logic tempWinHit = 1'b0, ovrEvt = 1'b0, cmpErrEvt = 1'b0;
  logic rdStb = 1'b0;
  logic [1:0] rdAddr = 2'd3;
  logic [SEL_W-1:0] chanSel = '0;
  logic [31:0] irqMask = '0;
  logic [31:0] rdData;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  adc_status_flags #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) dut (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .convDone(convDone),
    .tempWinHit(tempWinHit), .ovrEvt(ovrEvt), .cmpErrEvt(cmpErrEvt),
    .rdStb(rdStb), .rdAddr(rdAddr), .chanSel(chanSel), .irqMask(irqMask),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle read; returns rdData seen during the strobe
  task automatic doRead(input logic [1:0] a, input logic [SEL_W-1:0] s, output logic [31:0] d);
    rdStb = 1'b1; rdAddr = a; chanSel = s;
    #1 d = rdData;
    @(negedge clk);
    rdStb = 1'b0; rdAddr = 2'd3;
  endtask

  task automatic pulseConv(input logic [NUM_CH-1:0] m);
    convDone = m;
    @(negedge clk);
    convDone = '0;
  endtask

  task automatic clearAll();
    logic [31:0] d;
    for (int i = 0; i < NUM_CH; i++) doRead(2'd2, SEL_W'(i), d);
    doRead(2'd1, '0, d);
    doRead(2'd0, '0, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doRead(2'd0, '0, d);
    check("R1 reset status", d, 32'h0);
    check("R10 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_eoc_set();
    logic [31:0] d;
    pulseConv(12'h005);
    doRead(2'd0, '0, d);
    check("R2 eoc set and R5 drdy", d, 32'h0100_0005);
    pulseConv(12'h800);
    doRead(2'd0, '0, d);
    check("R2 eoc ch11", d, 32'h0100_0805);
    clearAll();
  endtask

  task automatic t_eoc_clear();
    logic [31:0] d;
    pulseConv(12'h00F);
    doRead(2'd2, 4'd2, d);
    doRead(2'd0, '0, d);
    check("R4 sel 2 clears only ch2", d, 32'h0100_000B);
    doRead(2'd2, 4'd13, d);
    doRead(2'd0, '0, d);
    check("R4 sel out of range keeps", d, 32'h0100_000B);
    doRead(2'd0, 4'd0, d);
    check("R4 status read keeps eoc", d, 32'h0100_000B);
    clearAll();
  endtask

  task automatic t_disable();
    logic [31:0] d;
    pulseConv(12'h003);
    chEnable = 12'hFFE;
    #1 doRead(2'd0, '0, d);
    check("R3 disabled reads zero", d, 32'h0100_0002);
    chEnable = 12'hFFF;
    @(negedge clk);
    doRead(2'd0, '0, d);
    check("R3 re-enable stays zero", d, 32'h0100_0002);
    clearAll();
    chEnable = 12'hFF7;
    pulseConv(12'h008);
    chEnable = 12'hFFF;
    @(negedge clk);
    doRead(2'd0, '0, d);
    check("R3 completion while disabled ignored", d, 32'h0);
  endtask

  task automatic t_drdy();
    logic [31:0] d;
    pulseConv(12'h010);
    doRead(2'd2, 4'd4, d);
    doRead(2'd0, '0, d);
    check("R5 drdy survives chan and status read", d, 32'h0100_0000);
    doRead(2'd1, '0, d);
    check("R9 last-data address returns zero", d, 32'h0);
    doRead(2'd0, '0, d);
    check("R5 last-data read clears drdy", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    ovrEvt = 1'b1; cmpErrEvt = 1'b1;
    @(negedge clk);
    ovrEvt = 1'b0; cmpErrEvt = 1'b0;
    doRead(2'd3, '0, d);
    check("R9 unused address returns zero", d, 32'h0);
    rdStb = 1'b0; rdAddr = 2'd0;
    @(negedge clk);
    doRead(2'd0, '0, d);
    check("R11 idle and addr3 did not clear, R6 set", d, 32'h0600_0000);
    doRead(2'd0, '0, d);
    check("R6 status read cleared sticky", d, 32'h0);
  endtask

  task automatic t_temp();
    logic [31:0] d;
    tempWinHit = 1'b1;
    @(negedge clk);
    tempWinHit = 1'b0;
    doRead(2'd0, '0, d);
    check("R7 window hit alone ignored", d, 32'h0);
    tempWinHit = 1'b1;
    pulseConv(12'h800);
    tempWinHit = 1'b0;
    doRead(2'd0, '0, d);
    check("R7 temp flag set", d, 32'h4100_0800);
    doRead(2'd0, '0, d);
    check("R7 temp cleared by status read", d, 32'h0100_0800);
    clearAll();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    ovrEvt = 1'b1;
    convDone = 12'h001;
    rdStb = 1'b1; rdAddr = 2'd0;
    #1 d = rdData;
    check("R9 pre-clear value during read", d, 32'h0);
    @(negedge clk);
    ovrEvt = 1'b0; convDone = '0;
    rdAddr = 2'd1;
    convDone = 12'h002;
    @(negedge clk);
    convDone = '0;
    rdAddr = 2'd2; chanSel = 4'd0;
    convDone = 12'h001;
    @(negedge clk);
    convDone = '0; rdStb = 1'b0; rdAddr = 2'd3;
    doRead(2'd0, '0, d);
    check("R8 set wins over clearing reads", d, 32'h0300_0003);
    clearAll();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulseConv(12'h020);
    irqMask = 32'h0000_0001;
    #1 check("R10 masked off", {31'd0, irq}, 32'd0);
    irqMask = 32'h0000_0020;
    #1 check("R10 eoc5 enabled", {31'd0, irq}, 32'd1);
    irqMask = 32'h0100_0000;
    #1 check("R10 drdy enabled", {31'd0, irq}, 32'd1);
    doRead(2'd1, '0, d);
    #1 check("R10 drops after clear", {31'd0, irq}, 32'd0);
    irqMask = '0;
    clearAll();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_eoc_set();
        t_eoc_clear();
        t_disable();
        t_drdy();
        t_sticky();
        t_temp();
        t_set_wins();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule